// File: doc/BRIEF.md
# Universal registered bus transceiver

This block connects two 18-bit bidirectional ports, A and B, and carries data without inversion from A to B and from B to A. Each direction has one storage stage, steered by two inputs: a pass control and a strobe. With pass high the destination follows the source. With pass low and the strobe steady, the stored word is held and presented. A falling strobe with pass low loads a new word from the source. One set of controls covers the whole width, so there are no per-byte enables.

Each destination port has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. A disabled port is released to high impedance. Strobes are not gated by the enables, so a word can be loaded while its destination is floating. All storage is clocked by a single system clock `clk`. Pass and strobe are sampled on its rising edge, and a strobe fall is recognised when one sample is high and the next is low. The path through to the destination port is combinational.

If a source port is being driven by the block itself, that direction's pass-through gives way to its stored word. The storage stage then samples the value the block puts on that port. This rule keeps the two directions from forming a loop when both are enabled.

Top module: `bus_xcvr18`

## Requirements
- R1: With `ab_oe` high, `ab_pass` high and `ba_oe_n` high, `b_io` equals the value on `a_io` in the same cycle, on all 18 bits.
- R2: With `ba_oe_n` low, `ba_pass` high and `ab_oe` low, `a_io` equals the value on `b_io` in the same cycle.
- R3: With a direction's pass input low and its strobe held steady high or low, the stored word of that direction is kept across clock edges and shown on the enabled destination port.
- R4: With pass low, a rising `clk` edge that samples the strobe low, where the previous edge sampled it high, loads the source port's value. The destination shows that value from that edge on, and not before.
- R5: While pass is high the stored word is reloaded at every rising edge, so after pass falls the destination shows the source value from the last edge at which pass was high.
- R6: `ab_oe` low releases `b_io` to high impedance, and `ba_oe_n` high releases `a_io` to high impedance.
- R7: A strobe fall loads the source value even while that direction's output enable is inactive; the word appears once the enable is asserted.
- R8: With both enables active and both pass inputs low, the stored A-to-B word drives `b_io` while the stored B-to-A word drives `a_io` at the same time.
- R9: When the source port of a direction is driven by the block, that direction's pass input does not bypass the store: the destination shows the stored word. With pass high, the store reloads from the value the block drives on the source port.
- R10: `rst` high at a rising edge clears both stored words and both strobe histories to zero, so an enabled port reads all zeros afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; storage and strobe sampling on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ab_oe | input | 1 | Drive enable for port B, active high |
| ba_oe_n | input | 1 | Drive enable for port A, active low |
| ab_pass | input | 1 | A-to-B pass-through control |
| ba_pass | input | 1 | B-to-A pass-through control |
| ab_strobe | input | 1 | A-to-B load strobe, falling transition loads |
| ba_strobe | input | 1 | B-to-A load strobe, falling transition loads |
| a_io | inout | 18 | Port A data |
| b_io | inout | 18 | Port B data |

## Verification
A stored word that is corrupted stays invisible while its direction passes through, or while its destination floats. It shows on the port in the first cycle in which pass is low and the enable is active, and it stays wrong until the next load. A strobe history register that is wrong moves a load by one edge, or creates or drops one. The port then shows the old word one edge too long, or the new word one edge early. The bench checks both ports in every cycle against a model of the stores, so any such divergence is reported in the cycle it first reaches a driven pin.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int XCVR_WIDTH = 18;

  typedef struct packed {
    logic pass;
    logic strobe;
  } dir_ctl_t;

endpackage

// File: rtl/xcvr_dir_store.sv
module xcvr_dir_store
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  dir_ctl_t     ctl,
  input  logic [W-1:0] src,
  output logic [W-1:0] stored,
  output logic         fall
);

  logic strobe_q;

  assign fall = strobe_q & ~ctl.strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      stored   <= '0;
    end else begin
      strobe_q <= ctl.strobe;
      if (ctl.pass || fall) begin
        stored <= src;
      end
    end
  end

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route #(
  parameter int W = 18
) (
  input  logic         pass,
  input  logic         src_self_driven,
  input  logic [W-1:0] src_pin,
  input  logic [W-1:0] stored,
  output logic [W-1:0] drive_val
);

  always_comb begin
    if (pass && !src_self_driven) begin
      drive_val = src_pin;
    end else begin
      drive_val = stored;
    end
  end

endmodule

// File: rtl/xcvr_pad.sv
module xcvr_pad #(
  parameter int W = 18
) (
  input  logic         en,
  input  logic [W-1:0] val,
  inout  wire  [W-1:0] pad,
  output logic [W-1:0] seen
);

  assign pad  = en ? val : {W{1'bz}};
  assign seen = en ? val : pad;

endmodule

// File: rtl/bus_xcvr18.sv
module bus_xcvr18
  import xcvr_pkg::*;
#(
  parameter int W = XCVR_WIDTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ab_oe,
  input  logic         ba_oe_n,
  input  logic         ab_pass,
  input  logic         ba_pass,
  input  logic         ab_strobe,
  input  logic         ba_strobe,
  inout  wire  [W-1:0] a_io,
  inout  wire  [W-1:0] b_io
);

  logic         a_en;
  logic         b_en;
  logic [W-1:0] a_val;
  logic [W-1:0] b_val;
  logic [W-1:0] a_seen;
  logic [W-1:0] b_seen;
  logic [W-1:0] qa;
  logic [W-1:0] qb;
  logic         ab_fall;
  logic         ba_fall;
  dir_ctl_t     ab_ctl;
  dir_ctl_t     ba_ctl;

  assign a_en = ~ba_oe_n;
  assign b_en = ab_oe;

  assign ab_ctl.pass   = ab_pass;
  assign ab_ctl.strobe = ab_strobe;
  assign ba_ctl.pass   = ba_pass;
  assign ba_ctl.strobe = ba_strobe;

  // Storage for each direction
  xcvr_dir_store #(.W(W)) u_ab_store (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ab_ctl),
    .src    (a_seen),
    .stored (qa),
    .fall   (ab_fall)
  );

  xcvr_dir_store #(.W(W)) u_ba_store (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ba_ctl),
    .src    (b_seen),
    .stored (qb),
    .fall   (ba_fall)
  );

  // Output selection: pass-through yields when the source is self-driven
  xcvr_route #(.W(W)) u_ab_route (
    .pass            (ab_pass),
    .src_self_driven (a_en),
    .src_pin         (a_io),
    .stored          (qa),
    .drive_val       (b_val)
  );

  xcvr_route #(.W(W)) u_ba_route (
    .pass            (ba_pass),
    .src_self_driven (b_en),
    .src_pin         (b_io),
    .stored          (qb),
    .drive_val       (a_val)
  );

  // Tri-state pads
  xcvr_pad #(.W(W)) u_pad_a (
    .en   (a_en),
    .val  (a_val),
    .pad  (a_io),
    .seen (a_seen)
  );

  xcvr_pad #(.W(W)) u_pad_b (
    .en   (b_en),
    .val  (b_val),
    .pad  (b_io),
    .seen (b_seen)
  );

endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         ab_oe,
  input logic         ba_oe_n,
  input logic         ab_pass,
  input logic         ba_pass,
  input logic         a_en,
  input logic         b_en,
  input logic [W-1:0] qa,
  input logic [W-1:0] qb,
  input logic [W-1:0] a_seen,
  input logic [W-1:0] b_seen,
  input logic         ab_fall,
  input logic         ba_fall
);

  AST_B_RELEASED: assert property (@(posedge clk) disable iff (rst)
    !ab_oe |-> !b_en); // R6

  AST_A_RELEASED: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |-> !a_en); // R6

  AST_AB_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && !ab_fall) |=> $stable(qa)); // R3

  AST_BA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && !ba_fall) |=> $stable(qb)); // R3

  AST_AB_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ab_pass && ab_fall) |=> (qa == $past(a_seen))); // R4

  AST_BA_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!ba_pass && ba_fall) |=> (qb == $past(b_seen))); // R4

  AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ab_pass |=> (qa == $past(a_seen))); // R5

  AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    ba_pass |=> (qb == $past(b_seen))); // R5

  AST_LOAD_UNGATED: assert property (@(posedge clk) disable iff (rst)
    (!ab_oe && ab_fall) |=> (qa == $past(a_seen))); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (qa == '0 && qb == '0)); // R10

endmodule

bind bus_xcvr18 xcvr_chk #(.W(W)) u_xcvr_chk (
  .clk     (clk),
  .rst     (rst),
  .ab_oe   (ab_oe),
  .ba_oe_n (ba_oe_n),
  .ab_pass (ab_pass),
  .ba_pass (ba_pass),
  .a_en    (a_en),
  .b_en    (b_en),
  .qa      (qa),
  .qb      (qb),
  .a_seen  (a_seen),
  .b_seen  (b_seen),
  .ab_fall (ab_fall),
  .ba_fall (ba_fall)
);

// File: tb/test_bus_xcvr18.sv
module test_bus_xcvr18;

  localparam int W          = 18;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 600;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst;
  logic ab_oe, ba_oe_n, ab_pass, ba_pass, ab_strobe, ba_strobe;
  logic         tb_a_en, tb_b_en;
  logic [W-1:0] tb_a_val, tb_b_val;
  wire  [W-1:0] a_io;
  wire  [W-1:0] b_io;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  assign a_io = tb_a_en ? tb_a_val : {W{1'bz}};
  assign b_io = tb_b_en ? tb_b_val : {W{1'bz}};
  pullup pu_a (a_io);
  pullup pu_b (b_io);

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_xcvr18 #(.W(W)) i_bus_xcvr18 (
    .clk       (clk),
    .rst       (rst),
    .ab_oe     (ab_oe),
    .ba_oe_n   (ba_oe_n),
    .ab_pass   (ab_pass),
    .ba_pass   (ba_pass),
    .ab_strobe (ab_strobe),
    .ba_strobe (ba_strobe),
    .a_io      (a_io),
    .b_io      (b_io)
  );

  // Reference model of the two stores
  logic [W-1:0] mqa = '0;
  logic [W-1:0] mqb = '0;
  logic         mab_prev = 1'b0;
  logic         mba_prev = 1'b0;

  function automatic logic [W-1:0] a_ext();
    return tb_a_en ? tb_a_val : {W{1'b1}};
  endfunction

  function automatic logic [W-1:0] b_ext();
    return tb_b_en ? tb_b_val : {W{1'b1}};
  endfunction

  function automatic logic [W-1:0] exp_a();
    if (ba_oe_n) return a_ext();
    return (ba_pass && !ab_oe) ? b_ext() : mqb;
  endfunction

  function automatic logic [W-1:0] exp_b();
    if (!ab_oe) return b_ext();
    return (ab_pass && ba_oe_n) ? a_ext() : mqa;
  endfunction

  function automatic string tag_b();
    if (!ab_oe) return "R6";
    if (ab_pass && ba_oe_n) return "R1";
    if (ab_pass) return "R9";
    if (!ba_oe_n) return "R8";
    return "R3";
  endfunction

  function automatic string tag_a();
    if (ba_oe_n) return "R6";
    if (ba_pass && !ab_oe) return "R2";
    if (ba_pass) return "R9";
    if (ab_oe) return "R8";
    return "R3";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mqa <= '0; mqb <= '0; mab_prev <= 1'b0; mba_prev <= 1'b0;
    end else begin
      if (ab_pass || (mab_prev && !ab_strobe)) mqa <= exp_a();
      if (ba_pass || (mba_prev && !ba_strobe)) mqb <= exp_b();
      mab_prev <= ab_strobe;
      mba_prev <= ba_strobe;
    end
  end

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%05h expected=%05h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic after_edge();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; ab_oe = 1'b1; ba_oe_n = 1'b0;
    ab_pass = 1'b0; ba_pass = 1'b0; ab_strobe = 1'b1; ba_strobe = 1'b1;
    tb_a_en = 1'b0; tb_b_en = 1'b0; tb_a_val = '0; tb_b_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R10", a_io, '0);
    check("R10", b_io, '0);

    // R1 transparent A to B
    @(negedge clk);
    ba_oe_n = 1'b1; ab_pass = 1'b1; tb_a_en = 1'b1; tb_a_val = 18'h2A5C3;
    #2 check("R1", b_io, 18'h2A5C3);
    tb_a_val = 18'h1D0B7;
    #1 check("R1", b_io, 18'h1D0B7);
    tb_a_val = 18'h2A5C3;

    // R5 last value seen while passing is kept
    @(negedge clk);
    ab_pass = 1'b0; tb_a_val = 18'h15A3C;
    #2 check("R5", b_io, 18'h2A5C3);

    // R3 strobe steady high
    @(negedge clk);
    tb_a_val = 18'h3FFFF;
    after_edge();
    check("R3", b_io, 18'h2A5C3);

    // R4 strobe fall loads
    @(negedge clk);
    ab_strobe = 1'b0; tb_a_val = 18'h0F0F0;
    #2 check("R3", b_io, 18'h2A5C3);
    after_edge();
    check("R4", b_io, 18'h0F0F0);
    @(negedge clk);
    tb_a_val = 18'h12345;
    after_edge();
    check("R3", b_io, 18'h0F0F0);

    // R6 / R7 load while B floats
    @(negedge clk);
    ab_oe = 1'b0; ab_strobe = 1'b1;
    #2 check("R6", b_io, {W{1'b1}});
    @(negedge clk);
    ab_strobe = 1'b0; tb_a_val = 18'h0A0A5;
    after_edge();
    check("R6", b_io, {W{1'b1}});
    @(negedge clk);
    ab_oe = 1'b1;
    #2 check("R7", b_io, 18'h0A0A5);

    // R2 transparent B to A
    @(negedge clk);
    ab_oe = 1'b0; tb_a_en = 1'b0; ba_oe_n = 1'b0; ba_pass = 1'b1;
    tb_b_en = 1'b1; tb_b_val = 18'h1C3E5;
    #2 check("R2", a_io, 18'h1C3E5);
    @(negedge clk);
    ba_pass = 1'b0; tb_b_val = 18'h00001;
    #2 check("R5", a_io, 18'h1C3E5);

    // R6 A side release
    @(negedge clk);
    ba_oe_n = 1'b1;
    #2 check("R6", a_io, {W{1'b1}});

    // R8 both stored words out together
    @(negedge clk);
    tb_b_en = 1'b0; ab_oe = 1'b1; ba_oe_n = 1'b0;
    #2 check("R8", a_io, 18'h1C3E5);
    check("R8", b_io, 18'h0A0A5);
    after_edge();
    check("R8", a_io, 18'h1C3E5);
    check("R8", b_io, 18'h0A0A5);

    // R9 self-driven source blocks bypass, store takes driven value
    @(negedge clk);
    ab_pass = 1'b1;
    #2 check("R9", b_io, 18'h0A0A5);
    after_edge();
    check("R9", b_io, 18'h1C3E5);
    check("R9", a_io, 18'h1C3E5);
    @(negedge clk);
    ab_pass = 1'b0;

    // Random phase against the model
    for (int i = 0; i < RAND_CYCLES; i++) begin
      @(negedge clk);
      ab_oe     = 1'($urandom);
      ba_oe_n   = 1'($urandom);
      ab_pass   = (($urandom % 4) == 0);
      ba_pass   = (($urandom % 4) == 0);
      ab_strobe = 1'($urandom);
      ba_strobe = 1'($urandom);
      tb_a_val  = W'($urandom);
      tb_b_val  = W'($urandom);
      tb_a_en   = ba_oe_n && (($urandom % 4) != 0);
      tb_b_en   = !ab_oe && (($urandom % 4) != 0);
      rst       = (($urandom % 97) == 0);
      #2;
      check(tag_a(), a_io, exp_a());
      check(tag_b(), b_io, exp_b());
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule